// File: doc/BRIEF.md
# Quad Halfword Add-Compare-Select Unit

This block performs one add-compare-select step of a trellis decoder on four lanes at once. Each 64-bit operand holds four signed 16-bit values. In every lane the transition metric from operand T is added to the metric from X and subtracted from the metric from S. The larger of the two candidates is kept and clamped to the signed 16-bit range. Two predicate bits per lane record whether the sum path won.

An operation is presented for one cycle with `in_valid` high. The four selected metrics, the 8-bit decision byte and the valid strobe appear from output registers after the next clock edge. A sticky overflow flag records that clamping took place in any lane. The flag stays set until the surrounding logic pulses `ovf_clr`. The block stores no metrics of its own: the caller supplies all three operands on every operation.

Top module: `acs_quad`

## Requirements
- R1: Lane i is taken from bits 16i+15 down to 16i of each operand for i = 0..3, and each lane value is read as a two's-complement signed number.
- R2: For each lane the candidates are a = X + T and b = S - T, computed without wrap-around, and the lane result is the larger of the two when that value lies in [-32768, 32767].
- R3: A selected value above 32767 is replaced by 0x7FFF in that lane. Because a + b = X + S is never below -65536, the selected value can never fall below -32768.
- R4: Decision bits 2i and 2i+1 of `pred_out` are both 1 when a > b in lane i, and both 0 otherwise. On a tie (a == b) both bits are 0 and the lane result is the common value.
- R5: Results, decisions and `out_valid` are registered. An operation sampled with `in_valid` high at a clock edge shows on the outputs right after that edge, with `out_valid` high for exactly that one cycle.
- R6: `ovf_flag` goes high at the edge that captures a valid operation in which any lane was clamped. It then stays high through later operations, with or without clamping, until it is cleared.
- R7: `ovf_clr` high at an edge drives `ovf_flag` low after that edge. If the same edge also captures a clamped valid operation, the flag stays high.
- R8: While `rst` is high at an edge, `res_out`, `pred_out`, `out_valid` and `ovf_flag` become 0.
- R9: Operand values present while `in_valid` is low have no effect: `res_out` and `pred_out` hold, `out_valid` is 0 and `ovf_flag` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| x_in | input | 64 | Path metrics added to T (four signed lanes) |
| s_in | input | 64 | Path metrics from which T is subtracted (four signed lanes) |
| t_in | input | 64 | Transition metrics (four signed lanes) |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Outputs hold a newly computed result |
| res_out | output | 64 | Selected and clamped metric per lane |
| pred_out | output | 8 | Two decision bits per lane |
| ovf_flag | output | 1 | Sticky clamp indicator |

## Verification
All results (metrics, decision byte, valid strobe and overflow flag) pass through exactly one register stage. Each is due right after the rising edge that samples the operation or the clear. The bench changes inputs on falling edges and reads every output a few nanoseconds after the following rising edge. It therefore always observes the state of the cycle just captured. Hold and ignore checks sample the outputs after the edge that saw `in_valid` low, before any new operation is presented.

// File: rtl/acs_pkg.sv
package acs_pkg;

    localparam int unsigned LANE_W  = 16;
    localparam int unsigned GUARD_W = 2;
    localparam int unsigned WIDE_W  = LANE_W + GUARD_W;

    typedef enum logic {
        PICK_DIFF = 1'b0,
        PICK_SUM  = 1'b1
    } acs_pick_e;

    typedef struct packed {
        logic [LANE_W-1:0] metric;
        acs_pick_e         pick;
        logic              clamped;
    } lane_out_t;

    function automatic logic signed [WIDE_W-1:0] widen(input logic [LANE_W-1:0] v);
        return {{GUARD_W{v[LANE_W-1]}}, v};
    endfunction

    function automatic logic [LANE_W-1:0] clamp16(input logic signed [WIDE_W-1:0] v,
                                                  output logic hit);
        logic signed [WIDE_W-1:0] hi;
        logic signed [WIDE_W-1:0] lo;
        hi = {{(GUARD_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
        lo = {{(GUARD_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
        if (v > hi) begin
            hit = 1'b1;
            return {1'b0, {(LANE_W-1){1'b1}}};
        end else if (v < lo) begin
            hit = 1'b1;
            return {1'b1, {(LANE_W-1){1'b0}}};
        end
        hit = 1'b0;
        return v[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/acs_lane.sv
module acs_lane
    import acs_pkg::*;
(
    input  logic [LANE_W-1:0] x_i,
    input  logic [LANE_W-1:0] s_i,
    input  logic [LANE_W-1:0] t_i,
    output lane_out_t         out_o
);

    logic signed [WIDE_W-1:0] sum_w;
    logic signed [WIDE_W-1:0] dif_w;
    logic signed [WIDE_W-1:0] best_w;
    logic                     hit;
    logic [LANE_W-1:0]        clamped_v;

    always_comb begin
        sum_w  = widen(x_i) + widen(t_i);
        dif_w  = widen(s_i) - widen(t_i);
        best_w = (sum_w > dif_w) ? sum_w : dif_w;
        clamped_v = clamp16(best_w, hit);
        out_o.metric  = clamped_v;
        out_o.pick    = (sum_w > dif_w) ? PICK_SUM : PICK_DIFF;
        out_o.clamped = hit;
    end

    // R3
    always_comb begin
        if (out_o.clamped)
            clamp_value_chk: assert (out_o.metric == {1'b0, {(LANE_W-1){1'b1}}}
                                  || out_o.metric == {1'b1, {(LANE_W-1){1'b0}}});
    end

endmodule

// File: rtl/acs_ovf_track.sv
module acs_ovf_track (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/acs_quad.sv
module acs_quad
    import acs_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LANES*LANE_W-1:0]   x_in,
    input  logic [LANES*LANE_W-1:0]   s_in,
    input  logic [LANES*LANE_W-1:0]   t_in,
    input  logic                      ovf_clr,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   res_out,
    output logic [2*LANES-1:0]        pred_out,
    output logic                      ovf_flag
);

    localparam int unsigned DATA_W = LANES * LANE_W;
    localparam int unsigned PRED_W = 2 * LANES;

    lane_out_t            lane_q [LANES];
    logic [DATA_W-1:0]    res_d;
    logic [PRED_W-1:0]    pred_d;
    logic [LANES-1:0]     lane_hit;
    logic                 any_hit;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        acs_lane u_lane (
            .x_i   (x_in[i*LANE_W +: LANE_W]),
            .s_i   (s_in[i*LANE_W +: LANE_W]),
            .t_i   (t_in[i*LANE_W +: LANE_W]),
            .out_o (lane_q[i])
        );
        assign res_d[i*LANE_W +: LANE_W] = lane_q[i].metric;
        assign pred_d[2*i]               = (lane_q[i].pick == PICK_SUM);
        assign pred_d[2*i+1]             = (lane_q[i].pick == PICK_SUM);
        assign lane_hit[i]               = lane_q[i].clamped;
    end

    assign any_hit = |lane_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_out   <= '0;
            pred_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_out  <= res_d;
                pred_out <= pred_d;
            end
        end
    end

    acs_ovf_track u_ovf (
        .clk    (clk),
        .rst    (rst),
        .set_i  (in_valid && any_hit),
        .clr_i  (ovf_clr),
        .flag_o (ovf_flag)
    );

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res_out) && $stable(pred_out)));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (res_out == '0 && pred_out == '0 && !out_valid && !ovf_flag));

endmodule

// File: tb/acs_quad_tb.sv
module acs_quad_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] x_in = '0;
    logic [63:0] s_in = '0;
    logic [63:0] t_in = '0;
    logic        ovf_clr = 1'b0;
    logic        out_valid;
    logic [63:0] res_out;
    logic [7:0]  pred_out;
    logic        ovf_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    acs_quad u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_in(x_in), .s_in(s_in), .t_in(t_in), .ovf_clr(ovf_clr),
        .out_valid(out_valid), .res_out(res_out), .pred_out(pred_out),
        .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Spec model: larger of X+T and S-T per lane, clamp, decision pair.
    task automatic model(input logic [63:0] x, input logic [63:0] s,
                         input logic [63:0] t, output logic [63:0] r,
                         output logic [7:0] p, output logic hit);
        hit = 1'b0;
        r = '0;
        p = '0;
        for (int i = 0; i < 4; i++) begin
            int a;
            int b;
            int m;
            a = int'(signed'(x[16*i +: 16])) + int'(signed'(t[16*i +: 16]));
            b = int'(signed'(s[16*i +: 16])) - int'(signed'(t[16*i +: 16]));
            m = (a > b) ? a : b;
            if (m > 32767) begin m = 32767; hit = 1'b1; end
            if (m < -32768) begin m = -32768; hit = 1'b1; end
            r[16*i +: 16] = m[15:0];
            p[2*i]   = (a > b);
            p[2*i+1] = (a > b);
        end
    endtask

    task automatic drive(input logic v, input logic [63:0] x, input logic [63:0] s,
                         input logic [63:0] t, input logic clr);
        @(negedge clk);
        in_valid = v; x_in = x; s_in = s; t_in = t; ovf_clr = clr;
        @(posedge clk);
        #5;
        @(negedge clk);
        in_valid = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic op_check(input string req, input logic [63:0] x,
                            input logic [63:0] s, input logic [63:0] t);
        logic [63:0] r;
        logic [7:0]  p;
        logic        h;
        model(x, s, t, r, p, h);
        @(negedge clk);
        in_valid = 1'b1; x_in = x; s_in = s; t_in = t;
        @(posedge clk);
        #5;
        check(req, "result", res_out, r);
        check(req, "pred", {56'd0, pred_out}, {56'd0, p});
        check("R5", "out_valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #5;
        check("R5", "valid one cycle", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_reset();
        #5;
        check("R8", "res", res_out, 64'd0);
        check("R8", "pred", {56'd0, pred_out}, 64'd0);
        check("R8", "valid", {63'd0, out_valid}, 64'd0);
        check("R8", "ovf", {63'd0, ovf_flag}, 64'd0);
    endtask

    task automatic t_basic();
        // R1 R2: distinct values per lane, mixed winners
        op_check("R2", 64'h0004_0100_0010_0003, 64'h0020_0050_0009_0002,
                 64'h0001_0002_0003_0001);
        // R1: negative lanes are sign extended
        op_check("R1", 64'hFFF0_8005_FF00_FFFE, 64'hFFE0_8010_FF10_FFFF,
                 64'hFFFF_0002_0005_FFFF);
    endtask

    task automatic t_tie();
        // R4: tie in every lane, decisions clear
        op_check("R4", 64'h0010_FFF0_0000_1000, 64'h001A_0000_000A_1400,
                 64'h0005_0008_0005_0200);
        check("R4", "tie result lane0", res_out[15:0], 16'h1200);
        // R4: sum wins only in lanes 3 and 1
        op_check("R4", 64'h0100_0000_0100_0000, 64'h0000_0100_0000_0100,
                 64'h0001_0001_0001_0001);
        check("R4", "pred pattern", {56'd0, pred_out}, 64'h00CC);
    endtask

    task automatic t_sat();
        // R3 R6: lane 2 clamps at top
        op_check("R3", 64'h0000_7000_0000_0000, 64'h0000_0000_0000_0000,
                 64'h0000_2000_0000_0000);
        check("R3", "lane2 clamp", res_out[47:32], 16'h7FFF);
        check("R6", "ovf set", {63'd0, ovf_flag}, 64'd1);
        // R3: extreme negatives stay in range, no clamp
        op_check("R3", 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000,
                 64'h0001_FFFF_8000_0000);
        // R6: sticky through a non-clamping op
        check("R6", "ovf sticky", {63'd0, ovf_flag}, 64'd1);
    endtask

    task automatic t_clear();
        drive(1'b0, '0, '0, '0, 1'b1);
        check("R7", "clear", {63'd0, ovf_flag}, 64'd0);
        // R7: clamp and clear on the same edge: set wins
        drive(1'b1, 64'h7FFF, 64'h0, 64'h7FFF, 1'b1);
        check("R7", "set wins", {63'd0, ovf_flag}, 64'd1);
        drive(1'b0, '0, '0, '0, 1'b1);
        check("R7", "clear again", {63'd0, ovf_flag}, 64'd0);
    endtask

    task automatic t_ignore();
        logic [63:0] r0;
        logic [7:0]  p0;
        r0 = res_out;
        p0 = pred_out;
        // R9: clamping operands with in_valid low
        drive(1'b0, 64'h7FFF_7FFF_7FFF_7FFF, 64'h0, 64'h7FFF_7FFF_7FFF_7FFF, 1'b0);
        check("R9", "res held", res_out, r0);
        check("R9", "pred held", {56'd0, pred_out}, {56'd0, p0});
        check("R9", "no valid", {63'd0, out_valid}, 64'd0);
        check("R9", "ovf untouched", {63'd0, ovf_flag}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_basic();
        t_tie();
        t_sat();
        t_clear();
        t_ignore();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule